// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block speeds up the discovery step of a one-wire ROM search. A single start strobe makes it run three bus slots in a fixed order through an external bit-level master. The first two are read slots that fetch an address bit and then its inverted copy. The block then picks the branch to follow and sends that bit back with a write slot. It returns a 3-bit code that reports what the two reads showed and which branch was taken.

A search controller drives the loop that walks the 64 address bits. At each bit position it gives a preferred branch and pulses start. It then waits for the done pulse and reads the code. The code shows whether no device answered, whether devices disagreed at this bit, or whether all devices that answered agreed on one value.

Top module: `owt_search_triplet`

## Requirements
- R1: During and after a synchronous reset, busy_o, done_o and slot_req_o are 0 and result_o is 3'b000.
- R2: When start_i is high while busy_o is low, the next cycle shows busy_o high and a one-cycle slot_req_o with slot_write_o low and slot_wbit_o high (a read slot). pref_dir_i is captured in that same cycle, and later changes to it have no effect.
- R3: Slots are requested in a fixed order: an address read, a complement read, then a write. Each slot_req_o is a single-cycle pulse. The next request comes in the cycle after the cycle in which slot_done_i is high, and never earlier.
- R4: When both read bits are 1, result_o becomes 3'b011, done_o pulses, and no write slot is requested.
- R5: When both read bits are 0, the write slot carries the captured preference. result_o is 3'b100 for preference 1 and 3'b000 for preference 0.
- R6: When the two read bits differ, the write slot carries the address bit. result_o is 3'b101 when that bit is 1 and 3'b010 when it is 0.
- R7: The result fields are: bit 0 is the address bit, bit 1 is the complement bit, and bit 2 is the bit that was written (0 in the error case). result_o holds its value until the next command completes.
- R8: done_o is high for exactly one cycle, the cycle after the cycle in which slot_done_i completes the last slot. result_o is valid in that cycle.
- R9: start_i is ignored while busy_o is high. No extra slot is requested, and the command in progress is not disturbed.
- R10: start_i is accepted in the same cycle in which done_o is high.
- R11: slot_done_i is ignored while the block is idle. It neither starts a slot nor changes busy_o or result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts one triplet command |
| pref_dir_i | input | 1 | Branch to take when both bit values are present |
| slot_req_o | output | 1 | One-cycle request for a bus slot |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot; valid with slot_req_o |
| slot_wbit_o | output | 1 | Bit to drive in the slot (1 for reads) |
| slot_done_i | input | 1 | Bit master reports that the slot has finished |
| slot_rbit_i | input | 1 | Sampled bus bit, valid with slot_done_i |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | 3 | {written bit, complement bit, address bit} |

## Verification
The cycle in which done_o pulses is also the first cycle in which a new start_i is accepted. The bench starts the next command exactly in that cycle and checks that a read request follows one cycle later, while the previous result stays correct. A second overlap is a start_i pulse sent partway through a command. The reference model must show that this pulse causes no extra slot and leaves the written bit unchanged, even though pref_dir_i has also been flipped.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int RES_W = 3;
  localparam logic [RES_W-1:0] RES_NORESP = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CMPL = 2'd2,
    ST_WBCK = 2'd3
  } owt_state_e;
endpackage

// File: rtl/owt_decide.sv
module owt_decide (
  input  logic addr_bit_i,
  input  logic cmpl_bit_i,
  input  logic pref_i,
  output logic no_resp_o,
  output logic dir_o
);
  // Both ones: nobody pulled the line low in either read.
  // Both zeros: devices disagree, follow the caller's preference.
  // Otherwise all responders agree on the address bit.
  always_comb begin
    no_resp_o = addr_bit_i & cmpl_bit_i;
    if (!addr_bit_i && !cmpl_bit_i) dir_o = pref_i;
    else                            dir_o = addr_bit_i;
  end
endmodule

// File: rtl/owt_seq.sv
module owt_seq
  import owt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             pref_i,
  input  logic             slot_done_i,
  input  logic             slot_rbit_i,
  input  logic             no_resp_i,
  input  logic             dir_i,
  output logic             addr_q_o,
  output logic             pref_q_o,
  output logic             slot_req_o,
  output logic             slot_write_o,
  output logic             slot_wbit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  owt_state_e state_q;
  logic addr_q, cmpl_q, pref_q, dir_q;
  logic req_q, wr_q, wb_q, done_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= 1'b0;
      cmpl_q  <= 1'b0;
      pref_q  <= 1'b0;
      dir_q   <= 1'b0;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      wb_q    <= 1'b1;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pref_q  <= pref_i;
            req_q   <= 1'b1;
            wr_q    <= 1'b0;
            wb_q    <= 1'b1;
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (slot_done_i) begin
            addr_q  <= slot_rbit_i;
            req_q   <= 1'b1;
            state_q <= ST_CMPL;
          end
        end
        ST_CMPL: begin
          if (slot_done_i) begin
            cmpl_q <= slot_rbit_i;
            if (no_resp_i) begin
              res_q   <= RES_NORESP;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              dir_q   <= dir_i;
              req_q   <= 1'b1;
              wr_q    <= 1'b1;
              wb_q    <= dir_i;
              state_q <= ST_WBCK;
            end
          end
        end
        ST_WBCK: begin
          if (slot_done_i) begin
            res_q   <= {dir_q, cmpl_q, addr_q};
            done_q  <= 1'b1;
            wr_q    <= 1'b0;
            wb_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_q_o     = addr_q;
  assign pref_q_o     = pref_q;
  assign slot_req_o   = req_q;
  assign slot_write_o = wr_q;
  assign slot_wbit_o  = wb_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;

  assert_start_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && slot_req_o && !slot_write_o && slot_wbit_o));
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    slot_req_o |=> !slot_req_o);
  assert_wait_done_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !slot_done_i) |=> (busy_o && !slot_req_o));
  assert_err_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o[1:0] == 2'b11) |-> !result_o[2]);
  assert_pref_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_req_o && slot_write_o && !addr_q && !cmpl_q) |-> (slot_wbit_o == pref_q));
  assert_addr_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_req_o && slot_write_o && (addr_q != cmpl_q)) |-> (slot_wbit_o == addr_q));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> (!busy_o && !slot_req_o && $stable(result_o)));
endmodule

// File: rtl/owt_search_triplet.sv
module owt_search_triplet
  import owt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             pref_dir_i,
  output logic             slot_req_o,
  output logic             slot_write_o,
  output logic             slot_wbit_o,
  input  logic             slot_done_i,
  input  logic             slot_rbit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  logic addr_q, pref_q, no_resp, dir;

  // The complement bit arrives on slot_rbit_i in the same cycle it is decided on.
  owt_decide i_decide (
    .addr_bit_i (addr_q),
    .cmpl_bit_i (slot_rbit_i),
    .pref_i     (pref_q),
    .no_resp_o  (no_resp),
    .dir_o      (dir)
  );

  owt_seq i_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .pref_i       (pref_dir_i),
    .slot_done_i  (slot_done_i),
    .slot_rbit_i  (slot_rbit_i),
    .no_resp_i    (no_resp),
    .dir_i        (dir),
    .addr_q_o     (addr_q),
    .pref_q_o     (pref_q),
    .slot_req_o   (slot_req_o),
    .slot_write_o (slot_write_o),
    .slot_wbit_o  (slot_wbit_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );
endmodule

// File: tb/test_owt_search_triplet.sv
`timescale 1ns/1ps
module test_owt_search_triplet;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, pref_dir_i = 1'b0;
  logic slot_done_i = 1'b0, slot_rbit_i = 1'b0;
  logic slot_req_o, slot_write_o, slot_wbit_o, busy_o, done_o;
  logic [2:0] result_o;

  always #4 clk = ~clk;

  owt_search_triplet i_owt_search_triplet (
    .clk(clk), .rst(rst), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .slot_req_o(slot_req_o), .slot_write_o(slot_write_o), .slot_wbit_o(slot_wbit_o),
    .slot_done_i(slot_done_i), .slot_rbit_i(slot_rbit_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit armed = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: phase 0 idle, 1..3 waiting on the three slots.
  int   m_ph = 0;
  logic m_req = 0, m_wr = 0, m_wb = 1, m_done = 0;
  logic m_id = 0, m_cp = 0, m_pref = 0, m_dir = 0;
  logic [2:0] m_res = 0;

  always @(posedge clk) begin
    armed <= 1;
    if (rst) begin
      m_ph = 0; m_req = 0; m_wr = 0; m_wb = 1; m_done = 0; m_res = 0;
    end else begin
      m_req = 0; m_done = 0;
      if (m_ph == 0) begin
        if (start_i) begin m_ph = 1; m_req = 1; m_wr = 0; m_wb = 1; m_pref = pref_dir_i; end
      end else if (m_ph == 1) begin
        if (slot_done_i) begin m_id = slot_rbit_i; m_ph = 2; m_req = 1; end
      end else if (m_ph == 2) begin
        if (slot_done_i) begin
          m_cp = slot_rbit_i;
          if (m_id && m_cp) begin m_res = 3'b011; m_done = 1; m_ph = 0; end
          else begin
            m_dir = (m_id == m_cp) ? m_pref : m_id;
            m_ph = 3; m_req = 1; m_wr = 1; m_wb = m_dir;
          end
        end
      end else begin
        if (slot_done_i) begin m_res = {m_dir, m_cp, m_id}; m_done = 1; m_ph = 0; m_wr = 0; m_wb = 1; end
      end
    end
  end

  // Per-clock comparison against the model, sampled away from the edge.
  always @(negedge clk) begin
    if (armed) begin
      check(busy_o == (m_ph != 0), "R9 busy", int'(busy_o), int'(m_ph != 0));
      check(done_o == m_done, "R8 done", int'(done_o), int'(m_done));
      check(slot_req_o == m_req, "R3 req", int'(slot_req_o), int'(m_req));
      if (m_req) begin
        check(slot_write_o == m_wr, "R3 kind", int'(slot_write_o), int'(m_wr));
        check(slot_wbit_o == m_wb, "R6 wbit", int'(slot_wbit_o), int'(m_wb));
      end
      check(result_o == m_res, "R7 result", int'(result_o), int'(m_res));
    end
  end

  // Bit-level master model.
  logic cur_id = 0, cur_cp = 0, spur = 0, wr_bit = 0;
  int bm_lat = 1, bm_cnt = 0, bm_n = 0, wr_seen = 0;
  always @(negedge clk) begin
    slot_done_i = spur;
    if (bm_cnt > 0) begin
      bm_cnt--;
      if (bm_cnt == 0) begin
        slot_done_i = 1;
        slot_rbit_i = (bm_n == 0) ? cur_id : (bm_n == 1) ? cur_cp : 1'b1;
        bm_n++;
      end
    end
    if (slot_req_o) begin
      bm_cnt = bm_lat;
      if (slot_write_o) begin wr_seen++; wr_bit = slot_wbit_o; end
    end
  end

  function automatic logic [2:0] ref_code(input logic id, input logic cp, input logic pref);
    if (id && cp) return 3'b011;
    if (!id && !cp) return pref ? 3'b100 : 3'b000;
    return id ? 3'b101 : 3'b010;
  endfunction

  task automatic run_cmd(input logic id, input logic cp, input logic pref,
                         input int lat, input bit poke, input bit b2b);
    logic [2:0] exp;
    if (!b2b) repeat (2) @(negedge clk);
    cur_id = id; cur_cp = cp; bm_lat = lat; bm_n = 0; wr_seen = 0;
    start_i = 1; pref_dir_i = pref;
    @(negedge clk);
    start_i = 0; pref_dir_i = ~pref;   // later preference changes must not matter (R5)
    check(slot_req_o && !slot_write_o && slot_wbit_o && busy_o, "R2 read slot after start",
          int'(slot_req_o), 1);
    if (poke) begin                    // start while busy is ignored (R9)
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
    end
    while (!done_o) @(negedge clk);
    exp = ref_code(id, cp, pref);
    check(result_o == exp, (exp == 3'b011) ? "R4 code" : (id == cp) ? "R5 code" : "R6 code",
          int'(result_o), int'(exp));
    check(wr_seen == ((exp == 3'b011) ? 0 : 1), "R4 write slot count", wr_seen,
          (exp == 3'b011) ? 0 : 1);
    if (exp != 3'b011) check(wr_bit == exp[2], "R7 written bit", int'(wr_bit), int'(exp[2]));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !slot_req_o && result_o == 0, "R1 reset state",
          int'(result_o), 0);
    rst = 0;
    @(negedge clk);
    check(!busy_o && !slot_req_o && result_o == 0, "R1 after reset", int'(busy_o), 0);

    run_cmd(1, 1, 0, 1, 0, 0);  // R4 no response
    run_cmd(0, 0, 1, 2, 0, 0);  // R5 discrepancy, pref 1
    run_cmd(0, 0, 0, 3, 1, 0);  // R5 pref 0 with mid-command start
    run_cmd(1, 0, 0, 1, 0, 0);  // R6 all ones
    run_cmd(0, 1, 1, 2, 1, 0);  // R6 all zeros
    run_cmd(1, 0, 1, 4, 0, 1);  // R10 start in the done cycle
    run_cmd(0, 0, 1, 1, 0, 1);  // R10 again, R5
    run_cmd(1, 1, 1, 5, 1, 0);  // R4 with poke

    // R11: stray completion while idle
    repeat (2) @(negedge clk);
    spur = 1;
    @(negedge clk);
    spur = 0;
    @(negedge clk);
    check(!busy_o && !slot_req_o, "R11 stray done ignored", int'(busy_o), 0);
    check(result_o == 3'b011, "R11 result held", int'(result_o), 3);
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule